// File: doc/BRIEF.md
# Conditional branch target resolver

This block evaluates a conditional branch whose destination comes from a special target register. One bundle of operands enters with a valid strobe: a four-bit option field, a five-bit selector into a 32-bit condition word, a link request, a wide/narrow mode flag, the loop counter, the target register and the current instruction address. From these the block decides whether the branch is taken and computes the next instruction address. It also produces the updated loop counter and the return address, each with its own write enable.

Every result is registered, so the bundle's answers appear one clock after the bundle is accepted, alongside an output valid. Beats may arrive on consecutive cycles. The target register is only read. No write-back path for it exists.

Top module: `brtgt_resolver`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` of the previous cycle. While `out_valid_o` is low, `cnt_we_o` and `link_we_o` are low.
- R2: When `opt_i[1]` (skip-count) is 0, `cnt_new_o` is `count_i` minus one, wrapping modulo 2^64, and `cnt_we_o` is 1 whether or not the branch is taken. When `opt_i[1]` is 1, `cnt_we_o` is 0.
- R3: When `opt_i[1]` is 1, the counter test passes. When `opt_i[3]` is also 1, the branch is always taken.
- R4: When `opt_i[1]` is 0, the counter test passes exactly when (decremented counter nonzero) XOR `opt_i[0]`. With `opt_i[0]`=0 it passes on nonzero; with 1 it passes on zero.
- R5: With `wide_mode_i`=1 the zero test covers all 64 counter bits. With 0 it covers only bits 31:0.
- R6: When `opt_i[3]` (skip-condition) is 1, the condition test passes regardless of `cond_i`.
- R7: When `opt_i[3]` is 0, the condition test passes exactly when bit `cond_i[31 - sel_i]` equals `opt_i[2]`. Selector 0 picks the most significant bit.
- R8: `taken_o` is 1 only when both the counter test and the condition test pass.
- R9: When taken, `next_pc_o` is `target_i` with bits 1:0 cleared.
- R10: When not taken, `next_pc_o` is `pc_i + 4`.
- R11: `link_we_o` follows `link_en_i` of an accepted beat. `link_val_o` is `pc_i + 4` whether or not the branch is taken.
- R12: After synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operand bundle valid |
| opt_i | input | 4 | Option field: [3] skip-condition, [2] condition sense, [1] skip-count, [0] count sense |
| sel_i | input | 5 | Condition bit selector, counted from the MSB |
| link_en_i | input | 1 | Request a return-address write |
| wide_mode_i | input | 1 | 1: 64-bit zero test, 0: 32-bit zero test |
| count_i | input | 64 | Loop counter value |
| target_i | input | 64 | Target register value |
| cond_i | input | 32 | Condition word |
| pc_i | input | 64 | Current instruction address |
| out_valid_o | output | 1 | Results valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 64 | Next instruction address |
| cnt_new_o | output | 64 | Updated loop counter |
| cnt_we_o | output | 1 | Loop counter write enable |
| link_val_o | output | 64 | Return address |
| link_we_o | output | 1 | Return address write enable |

## Verification
All results share the same latency. Operands driven before clock edge N produce the taken flag, next address, counter, return address, both enables and the output valid just after edge N, and they hold until edge N+1. The bench drives each beat on a falling edge and compares every output on the following falling edge, which is exactly one rising edge later, before the next beat is applied. Idle gaps are checked the same way, so a missing valid drop would be caught at the cycle where it is due.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  // Option field bit positions; the evaluation depends on these.
  localparam int OPT_W           = 4;
  localparam int OPT_SKIP_COND   = 3;
  localparam int OPT_COND_SENSE  = 2;
  localparam int OPT_SKIP_COUNT  = 1;
  localparam int OPT_COUNT_SENSE = 0;
endpackage

// File: rtl/brtgt_count_unit.sv
module brtgt_count_unit #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic [XLEN-1:0] count_i,
  input  logic            wide_mode_i,
  input  logic            skip_i,
  input  logic            sense_i,
  output logic [XLEN-1:0] count_o,
  output logic            pass_o
);
  logic [XLEN-1:0] dec_v;
  logic            wide_nz;
  logic            narrow_nz;
  logic            nz;

  always_comb begin
    dec_v   = count_i - XLEN'(1);
    count_o = skip_i ? count_i : dec_v;
  end

  assign wide_nz = |count_o;

  generate
    if (NARROW < XLEN) begin : g_narrow
      assign narrow_nz = |count_o[NARROW-1:0];
    end else begin : g_same
      assign narrow_nz = wide_nz;
    end
  endgenerate

  always_comb begin
    nz     = wide_mode_i ? wide_nz : narrow_nz;
    pass_o = skip_i | (nz ^ sense_i);
  end
endmodule

// File: rtl/brtgt_cond_unit.sv
module brtgt_cond_unit #(
  parameter int CRW  = 32,
  parameter int SELW = $clog2(CRW)
) (
  input  logic [CRW-1:0]  cond_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            skip_i,
  input  logic            sense_i,
  output logic            pass_o
);
  logic [SELW-1:0] idx;
  logic            bit_v;

  always_comb begin
    idx    = SELW'(CRW - 1) - sel_i;
    bit_v  = cond_i[idx];
    pass_o = skip_i | (bit_v == sense_i);
  end
endmodule

// File: rtl/brtgt_addr_unit.sv
module brtgt_addr_unit #(
  parameter int XLEN       = 64,
  parameter int ALIGN_BITS = 2,
  parameter int STEP       = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic            taken_i,
  output logic [XLEN-1:0] seq_pc_o,
  output logic [XLEN-1:0] next_pc_o
);
  localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << ALIGN_BITS) - XLEN'(1);

  logic [XLEN-1:0] aligned;

  always_comb begin
    seq_pc_o  = pc_i + XLEN'(STEP);
    aligned   = target_i & ~LOW_MASK;
    next_pc_o = taken_i ? aligned : seq_pc_o;
  end
endmodule

// File: rtl/brtgt_resolver.sv
module brtgt_resolver
  import brtgt_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NARROW     = 32,
  parameter int CRW        = 32,
  parameter int ALIGN_BITS = 2,
  parameter int STEP       = 4,
  parameter int SELW       = $clog2(CRW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid_i,
  input  logic [OPT_W-1:0] opt_i,
  input  logic [SELW-1:0]  sel_i,
  input  logic             link_en_i,
  input  logic             wide_mode_i,
  input  logic [XLEN-1:0]  count_i,
  input  logic [XLEN-1:0]  target_i,
  input  logic [CRW-1:0]   cond_i,
  input  logic [XLEN-1:0]  pc_i,
  output logic             out_valid_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  cnt_new_o,
  output logic             cnt_we_o,
  output logic [XLEN-1:0]  link_val_o,
  output logic             link_we_o
);
  logic [XLEN-1:0] cnt_comb;
  logic            cnt_pass;
  logic            cond_pass;
  logic            taken_comb;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] next_comb;

  brtgt_count_unit #(.XLEN(XLEN), .NARROW(NARROW)) u_count (
    .count_i     (count_i),
    .wide_mode_i (wide_mode_i),
    .skip_i      (opt_i[OPT_SKIP_COUNT]),
    .sense_i     (opt_i[OPT_COUNT_SENSE]),
    .count_o     (cnt_comb),
    .pass_o      (cnt_pass)
  );

  brtgt_cond_unit #(.CRW(CRW), .SELW(SELW)) u_cond (
    .cond_i  (cond_i),
    .sel_i   (sel_i),
    .skip_i  (opt_i[OPT_SKIP_COND]),
    .sense_i (opt_i[OPT_COND_SENSE]),
    .pass_o  (cond_pass)
  );

  assign taken_comb = cnt_pass & cond_pass;

  brtgt_addr_unit #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS), .STEP(STEP)) u_addr (
    .pc_i      (pc_i),
    .target_i  (target_i),
    .taken_i   (taken_comb),
    .seq_pc_o  (seq_pc),
    .next_pc_o (next_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      next_pc_o   <= '0;
      cnt_new_o   <= '0;
      cnt_we_o    <= 1'b0;
      link_val_o  <= '0;
      link_we_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      cnt_we_o    <= in_valid_i & ~opt_i[OPT_SKIP_COUNT];
      link_we_o   <= in_valid_i & link_en_i;
      if (in_valid_i) begin
        taken_o    <= taken_comb;
        next_pc_o  <= next_comb;
        cnt_new_o  <= cnt_comb;
        link_val_o <= seq_pc;
      end
    end
  end
endmodule

// File: rtl/brtgt_resolver_chk.sv
module brtgt_resolver_chk
  import brtgt_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NARROW     = 32,
  parameter int CRW        = 32,
  parameter int ALIGN_BITS = 2,
  parameter int STEP       = 4,
  parameter int SELW       = $clog2(CRW)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid_i,
  input logic [OPT_W-1:0] opt_i,
  input logic [SELW-1:0]  sel_i,
  input logic             link_en_i,
  input logic             wide_mode_i,
  input logic [XLEN-1:0]  count_i,
  input logic [XLEN-1:0]  target_i,
  input logic [CRW-1:0]   cond_i,
  input logic [XLEN-1:0]  pc_i,
  input logic             out_valid_o,
  input logic             taken_o,
  input logic [XLEN-1:0]  next_pc_o,
  input logic [XLEN-1:0]  cnt_new_o,
  input logic             cnt_we_o,
  input logic [XLEN-1:0]  link_val_o,
  input logic             link_we_o
);
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> !out_valid_o);
  assert_quiet_we_R1: assert property (@(posedge clk) disable iff (rst)
    !out_valid_o |-> (!cnt_we_o && !link_we_o));
  assert_cnt_we_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> (cnt_we_o == !$past(opt_i[OPT_SKIP_COUNT])));
  assert_cnt_dec_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !opt_i[OPT_SKIP_COUNT]) |=> (cnt_new_o == $past(count_i) - XLEN'(1)));
  assert_always_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && opt_i[OPT_SKIP_COUNT] && opt_i[OPT_SKIP_COND]) |=> taken_o);
  assert_target_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !opt_i[OPT_SKIP_COUNT] && opt_i[OPT_SKIP_COND]) |=>
      (!taken_o || next_pc_o[ALIGN_BITS-1:0] == '0));
  assert_seq_pc_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> (taken_o || next_pc_o == $past(pc_i) + XLEN'(STEP)));
  assert_link_we_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> (link_we_o == $past(link_en_i)));
  assert_link_val_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> (link_val_o == $past(pc_i) + XLEN'(STEP)));
endmodule

bind brtgt_resolver brtgt_resolver_chk #(
  .XLEN(XLEN), .NARROW(NARROW), .CRW(CRW),
  .ALIGN_BITS(ALIGN_BITS), .STEP(STEP), .SELW(SELW)
) u_chk (.*);

// File: tb/brtgt_resolver_tb.sv
module brtgt_resolver_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid_i;
  logic [3:0]  opt_i;
  logic [4:0]  sel_i;
  logic        link_en_i;
  logic        wide_mode_i;
  logic [63:0] count_i;
  logic [63:0] target_i;
  logic [31:0] cond_i;
  logic [63:0] pc_i;
  logic        out_valid_o;
  logic        taken_o;
  logic [63:0] next_pc_o;
  logic [63:0] cnt_new_o;
  logic        cnt_we_o;
  logic [63:0] link_val_o;
  logic        link_we_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  brtgt_resolver u_dut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .opt_i(opt_i), .sel_i(sel_i),
    .link_en_i(link_en_i), .wide_mode_i(wide_mode_i), .count_i(count_i),
    .target_i(target_i), .cond_i(cond_i), .pc_i(pc_i), .out_valid_o(out_valid_o),
    .taken_o(taken_o), .next_pc_o(next_pc_o), .cnt_new_o(cnt_new_o),
    .cnt_we_o(cnt_we_o), .link_val_o(link_val_o), .link_we_o(link_we_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one beat at a falling edge; check all outputs one rising edge later.
  // Valid stays high afterwards, so consecutive calls form back-to-back beats.
  task automatic beat(input string tag, input logic [3:0] opt, input logic [4:0] sel,
                      input logic lnk, input logic wide, input logic [63:0] cnt,
                      input logic [63:0] tgt, input logic [31:0] cr,
                      input logic [63:0] pc, input logic exp_taken);
    logic [63:0] ecnt;
    logic [63:0] enext;
    in_valid_i = 1'b1; opt_i = opt; sel_i = sel; link_en_i = lnk;
    wide_mode_i = wide; count_i = cnt; target_i = tgt; cond_i = cr; pc_i = pc;
    ecnt  = opt[1] ? cnt : cnt - 64'd1;
    enext = exp_taken ? {tgt[63:2], 2'b00} : pc + 64'd4;
    @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid", {63'd0, out_valid_o}, 64'd1);
    chk({tag, " taken"}, {63'd0, taken_o}, {63'd0, exp_taken});
    chk(exp_taken ? "R9 next_pc" : "R10 next_pc", next_pc_o, enext);
    chk("R2 cnt_we", {63'd0, cnt_we_o}, {63'd0, ~opt[1]});
    if (!opt[1]) chk("R2 cnt_new", cnt_new_o, ecnt);
    chk("R11 link_we", {63'd0, link_we_o}, {63'd0, lnk});
    chk("R11 link_val", link_val_o, pc + 64'd4);
  endtask

  task automatic idle_check();
    in_valid_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 idle valid", {63'd0, out_valid_o}, 64'd0);
    chk("R1 idle cnt_we", {63'd0, cnt_we_o}, 64'd0);
    chk("R1 idle link_we", {63'd0, link_we_o}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R12 valid", {63'd0, out_valid_o}, 64'd0);
    chk("R12 taken", {63'd0, taken_o}, 64'd0);
    chk("R12 next_pc", next_pc_o, 64'd0);
    chk("R12 cnt_new", cnt_new_o, 64'd0);
    chk("R12 link_val", link_val_o, 64'd0);
    chk("R12 we", {62'd0, cnt_we_o, link_we_o}, 64'd0);
  endtask

  task automatic t_unconditional();
    // R3: both tests skipped, unaligned target is aligned (R9)
    beat("R3", 4'b1010, 5'd3, 1'b0, 1'b1, 64'h5, 64'h0000_1234_5678_9ABF,
         32'h0, 64'h1000, 1'b1);
    idle_check();
  endtask

  task automatic t_counter_tests();
    // R4 nonzero, sense 0: taken
    beat("R4", 4'b1000, 5'd0, 1'b0, 1'b1, 64'd5, 64'h2002, 32'h0, 64'h3000, 1'b1);
    // R4 reaches zero, sense 0: not taken
    beat("R4", 4'b1000, 5'd0, 1'b0, 1'b1, 64'd1, 64'h2002, 32'h0, 64'h3004, 1'b0);
    // R4 reaches zero, sense 1: taken
    beat("R4", 4'b1001, 5'd0, 1'b0, 1'b1, 64'd1, 64'h4001, 32'h0, 64'h3008, 1'b1);
    // R2 wrap from zero to all ones: nonzero, taken
    beat("R2", 4'b1000, 5'd0, 1'b0, 1'b1, 64'd0, 64'h5000, 32'h0, 64'h300C, 1'b1);
    idle_check();
  endtask

  task automatic t_mode();
    // R5: decremented value 0x1_0000_0000; narrow test sees zero, wide sees nonzero
    beat("R5", 4'b1000, 5'd0, 1'b0, 1'b0, 64'h0000_0001_0000_0001, 64'h6000,
         32'h0, 64'h7000, 1'b0);
    beat("R5", 4'b1000, 5'd0, 1'b0, 1'b1, 64'h0000_0001_0000_0001, 64'h6000,
         32'h0, 64'h7004, 1'b1);
    // R5 narrow, low half nonzero
    beat("R5", 4'b1001, 5'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0003, 64'h6000,
         32'h0, 64'h7008, 1'b0);
    idle_check();
  endtask

  task automatic t_condition();
    // R7: selector 0 picks MSB, sense 1
    beat("R7", 4'b0110, 5'd0, 1'b0, 1'b1, 64'd9, 64'h8000, 32'h8000_0000, 64'h9000, 1'b1);
    // R7: selector 31 picks LSB (0), sense 1: not taken
    beat("R7", 4'b0110, 5'd31, 1'b0, 1'b1, 64'd9, 64'h8000, 32'h8000_0000, 64'h9004, 1'b0);
    // R7: selector 31, sense 0: taken
    beat("R7", 4'b0010, 5'd31, 1'b0, 1'b1, 64'd9, 64'h8003, 32'h8000_0000, 64'h9008, 1'b1);
    // R7: mid bit, selector 12 -> bit 19
    beat("R7", 4'b0110, 5'd12, 1'b0, 1'b1, 64'd9, 64'h8010, 32'h0008_0000, 64'h900C, 1'b1);
    // R6: skip-condition ignores a mismatching word
    beat("R6", 4'b1110, 5'd5, 1'b0, 1'b1, 64'd9, 64'h8020, 32'h0000_0000, 64'h9010, 1'b1);
    idle_check();
  endtask

  task automatic t_both();
    // R8: counter passes, condition fails
    beat("R8", 4'b0100, 5'd0, 1'b0, 1'b1, 64'd4, 64'hA000, 32'h0, 64'hB000, 1'b0);
    // R8: condition passes, counter fails
    beat("R8", 4'b0100, 5'd0, 1'b0, 1'b1, 64'd1, 64'hA000, 32'h8000_0000, 64'hB004, 1'b0);
    // R8: both pass
    beat("R8", 4'b0100, 5'd0, 1'b0, 1'b1, 64'd2, 64'hA00E, 32'h8000_0000, 64'hB008, 1'b1);
    idle_check();
  endtask

  task automatic t_link();
    // R11: link written when taken and when not taken
    beat("R11", 4'b1010, 5'd0, 1'b1, 1'b1, 64'd1, 64'hC000, 32'h0, 64'hFFFF_FFFF_FFFF_FFFC, 1'b1);
    beat("R11", 4'b1000, 5'd0, 1'b1, 1'b1, 64'd1, 64'hC000, 32'h0, 64'hD000, 1'b0);
    idle_check();
  endtask

  initial begin
    rst = 1'b1; in_valid_i = 1'b0; opt_i = '0; sel_i = '0; link_en_i = 1'b0;
    wide_mode_i = 1'b1; count_i = '0; target_i = '0; cond_i = '0; pc_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    idle_check();
    t_unconditional();
    t_counter_tests();
    t_mode();
    t_condition();
    t_both();
    t_link();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule